// File: doc/BRIEF.md
# Disk Geometry Binary-Search Prober

This block finds the head, cylinder and sector counts of a disk whose geometry is unknown. It sends trial seek requests to a disk controller and treats each pass or fail answer as a comparison: a seek that passes shows that the probed value exists, and a seek that fails shows that it does not. Each dimension is narrowed by halving an interval. Heads are resolved first, then cylinders, then sectors. While one dimension is being probed, every dimension already resolved is sent at its largest valid value and every dimension still to come is sent as zero.

A start pulse in the idle state begins a run. When an override enable is high at that start, no seek is issued and the override counts are reported at once. Each run ends with a one-cycle done strobe, and the three counts stay on the outputs until the next run completes. The controller state machine has four named states. ST_IDLE waits for start. It goes to ST_FINISH when the override is enabled, and otherwise it loads the bounds and goes to ST_PICK. ST_PICK looks at the current dimension. If that dimension is still open it goes to ST_WAIT. If it has converged, ST_PICK moves to the next dimension and stays in ST_PICK, or, after sectors, it latches the results and goes to ST_FINISH. ST_WAIT holds the seek request until a response arrives, then updates the bounds and returns to ST_PICK. ST_FINISH raises done for one cycle and returns to ST_IDLE.

Top module: `geom_prober`

## Requirements
- R1: A synchronous active-low reset clears done, seek_req and the three count outputs to 0, stops any search in progress and returns every bound to its initial value.
- R2: A start pulse in the idle state with ovr_en low begins a search. The first request carries head = HEAD_LIMIT/2, cylinder 0 and sector 0.
- R3: Each dimension keeps a lower bound, initially 0, and an exclusive upper bound, initially its limit (16 heads, 1024 cylinders, 64 sectors by default). The probe value is (lower+upper)/2, rounded down. A response with seek_ok=1 (pass) moves the lower bound to the probe value, and seek_ok=0 (fail) moves the upper bound to the probe value. A dimension with a power-of-two limit L therefore takes exactly log2(L) requests.
- R4: A dimension is finished when lower = upper-1, and its field is then fixed at the lower bound. Dimensions are searched in the order heads, cylinders, sectors. Dimensions not yet searched are sent as 0.
- R5: Only one request is outstanding at a time. seek_req stays high with its head, cylinder and sector fields unchanged until seek_resp is seen. It is low in the cycle after that response, and the next request cannot begin in that same cycle.
- R6: On completion, heads_out, cyls_out and secs_out each equal the final lower bound plus one, done is high for exactly one cycle, and the counts hold until the next completion.
- R7: A start pulse with ovr_en high issues no seek request. It reports ovr_heads, ovr_cyls and ovr_secs with done high in the cycle after start.
- R8: A start pulse while a search is running has no effect on that search or its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a run when the block is idle |
| ovr_en | input | 1 | Use the override counts instead of searching |
| ovr_heads | input | $clog2(HEAD_LIMIT+1) | Override head count |
| ovr_cyls | input | $clog2(CYL_LIMIT+1) | Override cylinder count |
| ovr_secs | input | $clog2(SEC_LIMIT+1) | Override sector count |
| seek_req | output | 1 | Trial seek request, held until a response arrives |
| seek_head | output | HEAD_FW | Head field of the request |
| seek_cyl | output | CYL_FW | Cylinder field of the request |
| seek_sec | output | SEC_FW | Sector field of the request |
| seek_resp | input | 1 | One-cycle response to the outstanding request |
| seek_ok | input | 1 | Result qualifier: 1 = pass, 0 = fail |
| done | output | 1 | One-cycle completion strobe |
| heads_out | output | $clog2(HEAD_LIMIT+1) | Discovered head count |
| cyls_out | output | $clog2(CYL_LIMIT+1) | Discovered cylinder count |
| secs_out | output | $clog2(SEC_LIMIT+1) | Discovered sector count |

## Verification
The bench builds the prober with limits of 16 heads, 16 cylinders and 8 sectors, and keeps the default field widths of 5, 10 and 6 bits. With these sizes the sweep can cover every one of the 2048 geometries, including the all-fail corner (1/1/1) and the all-pass corner (16/16/8). A disk model in the bench answers each request, and the bench checks both the counts reported for each geometry and the full sequence of probes, such as the frozen earlier fields and the 11 requests per run. Response delays vary from run to run. Further runs cover the override path, a start pulse that arrives mid-search, and a reset that arrives mid-search.

// File: rtl/gp_pkg.sv
package gp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PICK   = 2'd1,
        ST_WAIT   = 2'd2,
        ST_FINISH = 2'd3
    } gp_state_e;

    localparam int NDIM = 3;
    localparam logic [1:0] DIM_HEAD = 2'd0;
    localparam logic [1:0] DIM_CYL  = 2'd1;
    localparam logic [1:0] DIM_SEC  = 2'd2;

endpackage

// File: rtl/gp_bound.sv
module gp_bound #(
    parameter int LIMIT = 16,
    localparam int LW = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init,
    input  logic          upd,
    input  logic          ok,
    output logic [LW-1:0] lo_o,
    output logic [LW-1:0] mid_o,
    output logic          conv_o
);

    logic [LW-1:0] lo_q;
    logic [LW-1:0] hi_q;
    logic [LW:0]   sum;

    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            lo_q <= '0;
            hi_q <= LW'(LIMIT);
        end else if (upd) begin
            if (ok)
                lo_q <= mid_o;
            else
                hi_q <= mid_o;
        end
    end

    always_comb begin
        sum    = {1'b0, lo_q} + {1'b0, hi_q};
        mid_o  = sum[LW:1];
        lo_o   = lo_q;
        conv_o = ({1'b0, lo_q} + {{LW{1'b0}}, 1'b1}) >= {1'b0, hi_q};
    end

endmodule

// File: rtl/gp_ctrl.sv
module gp_ctrl
    import gp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            ovr_en,
    input  logic [NDIM-1:0] conv,
    input  logic            resp,
    output logic            init,
    output logic [NDIM-1:0] upd,
    output logic            seek_req,
    output logic [1:0]      dim,
    output logic            latch_res,
    output logic            latch_ovr,
    output logic            done
);

    gp_state_e  state_q, state_d;
    logic [1:0] dim_q, dim_d;
    logic       cur_conv;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dim_q   <= DIM_HEAD;
        end else begin
            state_q <= state_d;
            dim_q   <= dim_d;
        end
    end

    always_comb begin
        case (dim_q)
            DIM_HEAD: cur_conv = conv[0];
            DIM_CYL:  cur_conv = conv[1];
            DIM_SEC:  cur_conv = conv[2];
            default:  cur_conv = 1'b1;
        endcase
    end

    always_comb begin
        state_d = state_q;
        dim_d   = dim_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (ovr_en) begin
                        state_d = ST_FINISH;
                    end else begin
                        state_d = ST_PICK;
                        dim_d   = DIM_HEAD;
                    end
                end
            end
            ST_PICK: begin
                if (cur_conv) begin
                    if (dim_q == DIM_SEC)
                        state_d = ST_FINISH;
                    else
                        dim_d = dim_q + 2'd1;
                end else begin
                    state_d = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (resp)
                    state_d = ST_PICK;
            end
            ST_FINISH: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        init      = (state_q == ST_IDLE) && start && !ovr_en;
        latch_ovr = (state_q == ST_IDLE) && start && ovr_en;
        seek_req  = (state_q == ST_WAIT);
        upd       = '0;
        if ((state_q == ST_WAIT) && resp)
            upd = NDIM'(1) << dim_q;
        latch_res = (state_q == ST_PICK) && cur_conv && (dim_q == DIM_SEC);
        done      = (state_q == ST_FINISH);
        dim       = dim_q;
    end

endmodule

// File: rtl/geom_prober.sv
module geom_prober
    import gp_pkg::*;
#(
    parameter int HEAD_LIMIT = 16,
    parameter int CYL_LIMIT  = 1024,
    parameter int SEC_LIMIT  = 64,
    parameter int HEAD_FW    = 5,
    parameter int CYL_FW     = 10,
    parameter int SEC_FW     = 6,
    localparam int HCW = $clog2(HEAD_LIMIT + 1),
    localparam int CCW = $clog2(CYL_LIMIT + 1),
    localparam int SCW = $clog2(SEC_LIMIT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               ovr_en,
    input  logic [HCW-1:0]     ovr_heads,
    input  logic [CCW-1:0]     ovr_cyls,
    input  logic [SCW-1:0]     ovr_secs,
    output logic               seek_req,
    output logic [HEAD_FW-1:0] seek_head,
    output logic [CYL_FW-1:0]  seek_cyl,
    output logic [SEC_FW-1:0]  seek_sec,
    input  logic               seek_resp,
    input  logic               seek_ok,
    output logic               done,
    output logic [HCW-1:0]     heads_out,
    output logic [CCW-1:0]     cyls_out,
    output logic [SCW-1:0]     secs_out
);

    logic            init, latch_res, latch_ovr;
    logic [NDIM-1:0] upd, conv;
    logic [1:0]      dim;
    logic [HCW-1:0]  h_lo, h_mid;
    logic [CCW-1:0]  c_lo, c_mid;
    logic [SCW-1:0]  s_lo, s_mid;

    gp_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .ovr_en    (ovr_en),
        .conv      (conv),
        .resp      (seek_resp),
        .init      (init),
        .upd       (upd),
        .seek_req  (seek_req),
        .dim       (dim),
        .latch_res (latch_res),
        .latch_ovr (latch_ovr),
        .done      (done)
    );

    gp_bound #(.LIMIT(HEAD_LIMIT)) u_head (
        .clk(clk), .rst_n(rst_n), .init(init), .upd(upd[0]), .ok(seek_ok),
        .lo_o(h_lo), .mid_o(h_mid), .conv_o(conv[0])
    );

    gp_bound #(.LIMIT(CYL_LIMIT)) u_cyl (
        .clk(clk), .rst_n(rst_n), .init(init), .upd(upd[1]), .ok(seek_ok),
        .lo_o(c_lo), .mid_o(c_mid), .conv_o(conv[1])
    );

    gp_bound #(.LIMIT(SEC_LIMIT)) u_sec (
        .clk(clk), .rst_n(rst_n), .init(init), .upd(upd[2]), .ok(seek_ok),
        .lo_o(s_lo), .mid_o(s_mid), .conv_o(conv[2])
    );

    // Field formation: earlier dimensions frozen at lower bound, later ones zero
    always_comb begin
        seek_head = HEAD_FW'((dim == DIM_HEAD) ? h_mid : h_lo);
        unique case (dim)
            DIM_HEAD: seek_cyl = '0;
            DIM_CYL:  seek_cyl = CYL_FW'(c_mid);
            default:  seek_cyl = CYL_FW'(c_lo);
        endcase
        seek_sec = (dim == DIM_SEC) ? SEC_FW'(s_mid) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            heads_out <= '0;
            cyls_out  <= '0;
            secs_out  <= '0;
        end else if (latch_ovr) begin
            heads_out <= ovr_heads;
            cyls_out  <= ovr_cyls;
            secs_out  <= ovr_secs;
        end else if (latch_res) begin
            heads_out <= h_lo + HCW'(1);
            cyls_out  <= c_lo + CCW'(1);
            secs_out  <= s_lo + SCW'(1);
        end
    end

endmodule

// File: rtl/gp_prober_chk.sv
module gp_prober_chk #(
    parameter int HEAD_LIMIT = 16,
    parameter int CYL_LIMIT  = 1024,
    parameter int SEC_LIMIT  = 64,
    parameter int HEAD_FW    = 5,
    parameter int CYL_FW     = 10,
    parameter int SEC_FW     = 6,
    localparam int HCW = $clog2(HEAD_LIMIT + 1),
    localparam int CCW = $clog2(CYL_LIMIT + 1),
    localparam int SCW = $clog2(SEC_LIMIT + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               seek_req,
    input logic               seek_resp,
    input logic [HEAD_FW-1:0] seek_head,
    input logic [CYL_FW-1:0]  seek_cyl,
    input logic [SEC_FW-1:0]  seek_sec,
    input logic               done,
    input logic [HCW-1:0]     heads_out,
    input logic [CCW-1:0]     cyls_out,
    input logic [SCW-1:0]     secs_out
);

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seek_req && !seek_resp |=> seek_req);

    // R5
    req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seek_req && !seek_resp |=> $stable(seek_head) && $stable(seek_cyl) && $stable(seek_sec));

    // R5
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seek_req && seek_resp |=> !seek_req);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(heads_out) && $stable(cyls_out) && $stable(secs_out) || $rose(done));

    // R3
    probe_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seek_req |-> (int'(seek_head) < HEAD_LIMIT) && (int'(seek_cyl) < CYL_LIMIT)
                     && (int'(seek_sec) < SEC_LIMIT));

    // R4
    req_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seek_req |-> !done);

endmodule

bind geom_prober gp_prober_chk #(
    .HEAD_LIMIT(HEAD_LIMIT), .CYL_LIMIT(CYL_LIMIT), .SEC_LIMIT(SEC_LIMIT),
    .HEAD_FW(HEAD_FW), .CYL_FW(CYL_FW), .SEC_FW(SEC_FW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .seek_req(seek_req), .seek_resp(seek_resp),
    .seek_head(seek_head), .seek_cyl(seek_cyl), .seek_sec(seek_sec),
    .done(done), .heads_out(heads_out), .cyls_out(cyls_out), .secs_out(secs_out)
);

// File: tb/geom_prober_test.sv
module geom_prober_test;

    localparam int HL  = 16;
    localparam int CL  = 16;
    localparam int SL  = 8;
    localparam int HFW = 5;
    localparam int CFW = 10;
    localparam int SFW = 6;
    localparam int HCW = $clog2(HL + 1);
    localparam int CCW = $clog2(CL + 1);
    localparam int SCW = $clog2(SL + 1);
    localparam int NPROBE = $clog2(HL) + $clog2(CL) + $clog2(SL);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic           ovr_en = 1'b0;
    logic [HCW-1:0] ovr_heads = '0;
    logic [CCW-1:0] ovr_cyls = '0;
    logic [SCW-1:0] ovr_secs = '0;
    logic           seek_req;
    logic [HFW-1:0] seek_head;
    logic [CFW-1:0] seek_cyl;
    logic [SFW-1:0] seek_sec;
    logic           seek_resp = 1'b0;
    logic           seek_ok = 1'b0;
    logic           done;
    logic [HCW-1:0] heads_out;
    logic [CCW-1:0] cyls_out;
    logic [SCW-1:0] secs_out;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    geom_prober #(
        .HEAD_LIMIT(HL), .CYL_LIMIT(CL), .SEC_LIMIT(SL),
        .HEAD_FW(HFW), .CYL_FW(CFW), .SEC_FW(SFW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .ovr_en(ovr_en),
        .ovr_heads(ovr_heads), .ovr_cyls(ovr_cyls), .ovr_secs(ovr_secs),
        .seek_req(seek_req), .seek_head(seek_head), .seek_cyl(seek_cyl),
        .seek_sec(seek_sec), .seek_resp(seek_resp), .seek_ok(seek_ok),
        .done(done), .heads_out(heads_out), .cyls_out(cyls_out), .secs_out(secs_out)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One search against a model disk of h heads, c cylinders, s sectors
    task automatic run_one(input int h, input int c, input int s, input bit poke);
        int  n_req = 0;
        int  seq_bad = 0;
        int  cycles = 0;
        bit  finished = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (!finished && cycles < 400) begin
            if (done) begin
                finished = 1;
            end else begin
                if (seek_req) begin
                    int hd = int'(seek_head);
                    int cy = int'(seek_cyl);
                    int sc = int'(seek_sec);
                    int dly = (h + c + s + n_req) % 2;
                    if (n_req == 0 && (hd != HL/2 || cy != 0 || sc != 0)) seq_bad++;
                    if (n_req < $clog2(HL)) begin
                        if (cy != 0 || sc != 0) seq_bad++;
                    end else if (n_req < $clog2(HL) + $clog2(CL)) begin
                        if (hd != h - 1 || sc != 0 || cy == 0) seq_bad++;
                    end else begin
                        if (hd != h - 1 || cy != c - 1) seq_bad++;
                    end
                    if (poke && n_req == 0) dly = dly + 1;
                    for (int k = 0; k < dly; k++) begin
                        start = (poke && n_req == 0);
                        @(negedge clk);
                        start = 1'b0;
                        if (!seek_req || int'(seek_head) != hd || int'(seek_cyl) != cy
                            || int'(seek_sec) != sc) seq_bad++;
                    end
                    seek_resp = 1'b1;
                    seek_ok = (hd < h) && (cy < c) && (sc < s);
                    @(negedge clk);
                    seek_resp = 1'b0;
                    seek_ok = 1'b0;
                    if (seek_req) seq_bad++;
                    n_req++;
                end
                @(negedge clk);
                cycles++;
            end
        end
        check("R6", "done seen", int'(finished), 1);
        check("R6", "heads", int'(heads_out), h);
        check("R6", "cyls", int'(cyls_out), c);
        check("R6", "secs", int'(secs_out), s);
        check("R3", "probe count", n_req, NPROBE);
        check("R4", "sequence errors (R2/R5 ordering)", seq_bad, 0);
        if (poke) check("R8", "start during search kept result", int'(heads_out) * 10000
                        + int'(cyls_out) * 100 + int'(secs_out), h * 10000 + c * 100 + s);
        @(negedge clk);
        check("R6", "done one cycle", int'(done), 0);
        check("R6", "count hold", int'(heads_out), h);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "done in reset", int'(done), 0);
        check("R1", "seek_req in reset", int'(seek_req), 0);
        check("R1", "heads in reset", int'(heads_out), 0);
        check("R1", "cyls in reset", int'(cyls_out), 0);
        check("R1", "secs in reset", int'(secs_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "idle after reset", int'(seek_req), 0);

        // R7 override path
        ovr_heads = 5'd9; ovr_cyls = 5'd13; ovr_secs = 4'd3; ovr_en = 1'b1;
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        check("R7", "done after start", int'(done), 1);
        check("R7", "no request", int'(seek_req), 0);
        check("R7", "heads", int'(heads_out), 9);
        check("R7", "cyls", int'(cyls_out), 13);
        check("R7", "secs", int'(secs_out), 3);
        @(negedge clk);
        check("R7", "done pulse ends", int'(done), 0);
        ovr_en = 1'b0;

        // R1 reset in the middle of a search
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        @(negedge clk);
        check("R2", "request raised", int'(seek_req), 1);
        check("R2", "first head probe", int'(seek_head), HL / 2);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "req cleared by reset", int'(seek_req), 0);
        check("R1", "heads cleared by reset", int'(heads_out), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "stays idle", int'(seek_req), 0);

        // Exhaustive geometry sweep
        for (int h = 1; h <= HL; h++)
            for (int c = 1; c <= CL; c++)
                for (int s = 1; s <= SL; s++)
                    run_one(h, c, s, ((h + c + s) % 7) == 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule